// File: doc/BRIEF.md
# Hash Message Padder

This unit sits in front of a 512-bit block hash core (MD5 or SHA-1) and turns a message, delivered one byte per beat, into the 32-bit word stream that the core consumes in chunks of sixteen words. It packs the payload bytes into words, appends the 0x80 end marker, inserts zero fill, and closes the message with the 64-bit bit-length field, opening an extra chunk when the marker leaves no room for the length.

Each message begins with a one-cycle start pulse. The pulse also captures the algorithm and a 64-bit bit-count offset. The offset lets a message that continues from a precomputed keyed state, such as the inner or outer pass of a keyed hash, report a length that includes the 512 prefix bits the core never saw. Byte order inside words and inside the length field follows the selected algorithm. After every sixteenth word the unit pauses so the core can compress the chunk. It resumes only once the core's busy input is seen low.

Top module: `msg_padder`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `chunk_end` and `done` are low, and they stay low until a start pulse arrives.
- R2: A start pulse clears the byte count, the partly assembled word, the byte position and the word index, even in the middle of a message. It also captures `alg_sha` and `bit_offset`. The unit accepts bytes from the next cycle on, and any earlier partial message has no effect on what follows.
- R3: With `alg_sha`=0 (MD5), the first byte of each word goes to bits 7:0 and the fourth to bits 31:24. With `alg_sha`=1 (SHA-1), the first byte goes to bits 31:24 and the fourth to bits 7:0. A word is emitted when its fourth byte is accepted, and cycles with `in_valid` low add nothing.
- R4: The byte 0x80 goes into the byte position right after the last payload byte. If the last byte completed a word, the marker opens a new word at position one. The rest of the marker word is zero.
- R5: After the marker word, zero words follow up to word index 13 of the chunk, and the length field occupies word indexes 14 and 15.
- R6: If the marker word lands at word index 14 or 15, the chunk is zero-filled to index 15 and closed. A further chunk then carries 14 zero words and the length field.
- R7: The length value is `bit_offset` plus 8 times the payload byte count, modulo 2^64. With MD5, word 14 holds bits 31:0 and word 15 holds bits 63:32. With SHA-1, word 14 holds bits 63:32 and word 15 holds bits 31:0.
- R8: `chunk_end` is high together with every sixteenth `out_valid` word of a message. `done` is high only together with the final word, which also carries `chunk_end`.
- R9: After a chunk that is not the last one, neither `out_valid` nor `in_ready` is high for at least two cycles. Both stay low for as long as `hash_busy` is sampled high.
- R10: A message ended by a beat with `in_last` and `in_empty` high and no payload bytes yields exactly one chunk: word 0 holds only the marker, and the length is `bit_offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a new message |
| alg_sha | input | 1 | Algorithm captured at start: 1 for SHA-1, 0 for MD5 |
| bit_offset | input | 64 | Bits added to the length field, captured at start |
| in_valid | input | 1 | Input beat present |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Beat ends the message |
| in_empty | input | 1 | Beat carries no byte (used with in_last) |
| in_ready | output | 1 | Unit accepts a beat this cycle |
| hash_busy | input | 1 | Downstream core still compressing a chunk |
| out_valid | output | 1 | Output word present |
| out_word | output | 32 | Message, marker, fill or length word |
| chunk_end | output | 1 | Word is the sixteenth of its chunk |
| done | output | 1 | Word is the final one of the message |

## Verification
A wrong byte position or a stale assembly register shows up as a corrupted word at the next four-byte boundary. The marker word in the very same message also comes out wrong. A bad word index or fill decision moves the length field out of words 14 and 15, or changes the chunk count, so `chunk_end` and `done` fall on the wrong word within one chunk of the error. A byte-count or offset fault only shows in the last two words of the message. Messages of 55, 56, 62 and 64 bytes, an empty one, a large offset and a restart in mid-message are checked word by word against a byte-stream model.

// File: rtl/mpad_pkg.sv
package mpad_pkg;
  localparam int WORD_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int LANES       = WORD_W / BYTE_W;
  localparam int POS_W       = $clog2(LANES);
  localparam int CHUNK_WORDS = 16;
  localparam int IDX_W       = $clog2(CHUNK_WORDS);
  localparam int LEN_W       = 2 * WORD_W;
  localparam int LEN_WORDS   = LEN_W / WORD_W;
  localparam int SHIFT_W     = $clog2(BYTE_W);
  localparam int CNT_W       = LEN_W - SHIFT_W;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_WORDS - 1);
  localparam logic [IDX_W-1:0] LEN_IDX  = IDX_W'(CHUNK_WORDS - LEN_WORDS);
  localparam logic [IDX_W-1:0] FILL_IDX = IDX_W'(CHUNK_WORDS - LEN_WORDS - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LANES - 1);
  localparam logic [BYTE_W-1:0] MARKER  = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_MARK,
    ST_ZERO,
    ST_LEN0,
    ST_LEN1,
    ST_HOLD,
    ST_WAIT
  } pad_state_e;
endpackage

// File: rtl/mpad_packer.sv
module mpad_packer
  import mpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              flush,
  input  logic              mark,
  input  logic              msb_first,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word_out,
  output logic [POS_W-1:0]  pos_out
);
  logic [WORD_W-1:0] asm_q, asm_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [POS_W-1:0]  lane;
  logic [BYTE_W-1:0] ins;
  logic              asm_en;

  // lane of the current byte position, per byte order of the algorithm
  always_comb begin
    lane = msb_first ? (LAST_POS - pos_q) : pos_q;
    ins  = mark ? MARKER : byte_in;
    word_out = asm_q;
    word_out[lane*BYTE_W +: BYTE_W] = ins;
  end

  always_comb begin
    asm_d  = asm_q;
    pos_d  = pos_q;
    asm_en = 1'b0;
    if (clr || flush) begin
      asm_d  = '0;
      pos_d  = '0;
      asm_en = 1'b1;
    end else if (take) begin
      asm_d  = word_out;
      pos_d  = pos_q + 1'b1;
      asm_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
      pos_q <= '0;
    end else if (asm_en) begin
      asm_q <= asm_d;
      pos_q <= pos_d;
    end
  end

  assign pos_out = pos_q;

  // R3
  full_word_flushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && pos_q == LAST_POS) |-> flush);
endmodule

// File: rtl/mpad_bitcount.sv
module mpad_bitcount
  import mpad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] offset,
  input  logic             inc,
  output logic [LEN_W-1:0] total
);
  logic [LEN_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (load) begin
      off_q <= offset;
    end
  end

  assign total = off_q + {cnt_q, {SHIFT_W{1'b0}}};

  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> total == $past(total) + LEN_W'(BYTE_W));

  // R2
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> total == $past(offset));
endmodule

// File: rtl/mpad_ctrl.sv
module mpad_ctrl
  import mpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              alg_sel,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_empty,
  input  logic              hash_busy,
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] packed_word,
  input  logic [LEN_W-1:0]  total_bits,
  output logic              msb_first,
  output logic              in_ready,
  output logic              take,
  output logic              flush,
  output logic              mark,
  output logic              clr,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              chunk_end,
  output logic              done
);
  pad_state_e        st_q, st_d, after, resume_q, resume_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              fit_q, fit_d;
  logic              alg_q;
  logic              emit, last_slot;
  logic [WORD_W-1:0] emit_word;
  logic [WORD_W-1:0] len_hi, len_lo;
  logic              ov_q, ce_q, done_q;
  logic [WORD_W-1:0] word_q;

  assign len_hi = total_bits[LEN_W-1 -: WORD_W];
  assign len_lo = total_bits[WORD_W-1:0];

  assign msb_first = alg_q;
  assign in_ready  = (st_q == ST_DATA);
  assign take      = (st_q == ST_DATA) && in_valid && !in_empty;
  assign mark      = (st_q == ST_MARK);
  assign flush     = (take && pos == LAST_POS) || mark;
  assign clr       = start;

  // next-state logic
  always_comb begin
    emit      = 1'b0;
    emit_word = '0;
    after     = st_q;
    fit_d     = fit_q;
    case (st_q)
      ST_DATA: begin
        if (in_valid) begin
          if (take && pos == LAST_POS) begin
            emit      = 1'b1;
            emit_word = packed_word;
          end
          if (in_last) after = ST_MARK;
        end
      end
      ST_MARK: begin
        emit      = 1'b1;
        emit_word = packed_word;
        fit_d     = (idx_q <= FILL_IDX);
        after     = (idx_q == FILL_IDX) ? ST_LEN0 : ST_ZERO;
      end
      ST_ZERO: begin
        emit  = 1'b1;
        after = (fit_q && idx_q == FILL_IDX) ? ST_LEN0 : ST_ZERO;
      end
      ST_LEN0: begin
        emit      = 1'b1;
        emit_word = alg_q ? len_hi : len_lo;
        after     = ST_LEN1;
      end
      ST_LEN1: begin
        emit      = 1'b1;
        emit_word = alg_q ? len_lo : len_hi;
        after     = ST_IDLE;
      end
      ST_HOLD: after = ST_WAIT;
      ST_WAIT: if (!hash_busy) after = resume_q;
      default: after = st_q;
    endcase

    last_slot = emit && (idx_q == LAST_IDX);
    st_d      = after;
    resume_d  = resume_q;
    if (last_slot) begin
      fit_d = 1'b1;
      if (after != ST_IDLE) begin
        st_d     = ST_HOLD;
        resume_d = after;
      end
    end
    idx_d = emit ? idx_q + 1'b1 : idx_q;

    if (start) begin
      st_d     = ST_DATA;
      resume_d = ST_DATA;
      idx_d    = '0;
      fit_d    = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      resume_q <= ST_IDLE;
      idx_q    <= '0;
      fit_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      resume_q <= resume_d;
      idx_q    <= idx_d;
      fit_q    <= fit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alg_q <= 1'b0;
    end else if (start) begin
      alg_q <= alg_sel;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      ce_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ov_q   <= emit && !start;
      ce_q   <= last_slot && !start;
      done_q <= emit && (st_q == ST_LEN1) && !start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (emit) begin
      word_q <= emit_word;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = word_q;
  assign chunk_end = ce_q;
  assign done      = done_q;

  // checker: words seen at the output since the last chunk boundary
  logic [IDX_W-1:0] vcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
    end else if (start) begin
      vcnt_q <= '0;
    end else if (ov_q) begin
      vcnt_q <= ce_q ? '0 : vcnt_q + 1'b1;
    end
  end

  // R8
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |-> (ov_q && vcnt_q == LAST_IDX));

  // R8
  done_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ce_q);

  // R9
  pause_after_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !done_q && !start) |=> (!in_ready && !ov_q));

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && hash_busy && !start) |=> (!in_ready && !ov_q));

  // R5
  length_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEN0) |-> (idx_q == LEN_IDX));
endmodule

// File: rtl/msg_padder.sv
module msg_padder
  import mpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              alg_sha,
  input  logic [LEN_W-1:0]  bit_offset,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_empty,
  output logic              in_ready,
  input  logic              hash_busy,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              chunk_end,
  output logic              done
);
  logic              msb_first, take, flush, mark, clr;
  logic [WORD_W-1:0] packed_word;
  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  total_bits;

  mpad_packer u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .take      (take),
    .flush     (flush),
    .mark      (mark),
    .msb_first (msb_first),
    .byte_in   (in_data),
    .word_out  (packed_word),
    .pos_out   (pos)
  );

  mpad_bitcount u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (clr),
    .offset (bit_offset),
    .inc    (take),
    .total  (total_bits)
  );

  mpad_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .alg_sel     (alg_sha),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_empty    (in_empty),
    .hash_busy   (hash_busy),
    .pos         (pos),
    .packed_word (packed_word),
    .total_bits  (total_bits),
    .msb_first   (msb_first),
    .in_ready    (in_ready),
    .take        (take),
    .flush       (flush),
    .mark        (mark),
    .clr         (clr),
    .out_valid   (out_valid),
    .out_word    (out_word),
    .chunk_end   (chunk_end),
    .done        (done)
  );
endmodule

// File: tb/msg_padder_test.sv
module msg_padder_test;
  localparam int CLK_P    = 10;
  localparam int BUSY_CYC = 5;
  localparam int WD_CYC   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        alg_sha = 1'b0;
  logic [63:0] bit_offset = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_empty = 1'b0;
  logic        in_ready;
  logic        hash_busy;
  logic        out_valid;
  logic [31:0] out_word;
  logic        chunk_end;
  logic        done;

  int nchk = 0;
  int nerr = 0;

  msg_padder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .alg_sha    (alg_sha),
    .bit_offset (bit_offset),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_empty   (in_empty),
    .in_ready   (in_ready),
    .hash_busy  (hash_busy),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .chunk_end  (chunk_end),
    .done       (done)
  );

  always #(CLK_P/2) clk = ~clk;

  // downstream core model: busy for BUSY_CYC cycles after each chunk
  int bcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_busy <= 1'b0;
      bcnt      <= 0;
    end else if (chunk_end) begin
      hash_busy <= 1'b1;
      bcnt      <= BUSY_CYC;
    end else if (bcnt > 1) begin
      bcnt <= bcnt - 1;
    end else if (bcnt == 1) begin
      bcnt      <= 0;
      hash_busy <= 1'b0;
    end
  end

  // output capture, sampled away from the active edge
  logic [31:0] cap_word [0:63];
  logic        cap_ce   [0:63];
  logic        cap_done [0:63];
  int          ncap = 0;
  int          stall_err = 0;
  bit          done_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && ncap < 64) begin
        cap_word[ncap] = out_word;
        cap_ce[ncap]   = chunk_end;
        cap_done[ncap] = done;
        ncap = ncap + 1;
        if (done) done_seen = 1'b1;
      end
      if (hash_busy && (out_valid || in_ready)) stall_err = stall_err + 1;
    end
  end

  logic [7:0]  msg [0:255];
  int          msg_len;
  logic [31:0] exp_word [0:63];
  int          exp_n;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill_msg(input int len, input int seed);
    msg_len = len;
    for (int i = 0; i < len; i++) msg[i] = 8'((i * 7 + seed) & 8'hff);
  endtask

  // model: byte stream with marker, zeros and length, then word packing
  task automatic build_expected(input bit sha, input logic [63:0] off);
    logic [7:0]  eb [0:319];
    logic [63:0] lenv;
    int n;
    for (int i = 0; i < msg_len; i++) eb[i] = msg[i];
    n = msg_len;
    eb[n] = 8'h80;
    n++;
    while (n % 64 != 56) begin
      eb[n] = 8'h00;
      n++;
    end
    lenv = off + 64'(msg_len) * 64'd8;
    for (int k = 0; k < 8; k++)
      eb[n+k] = sha ? lenv[63-8*k -: 8] : lenv[8*k +: 8];
    n = n + 8;
    exp_n = n / 4;
    for (int w = 0; w < exp_n; w++)
      exp_word[w] = sha ? {eb[4*w], eb[4*w+1], eb[4*w+2], eb[4*w+3]}
                        : {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
  endtask

  task automatic pulse_start(input bit sha, input logic [63:0] off);
    @(negedge clk);
    start = 1'b1;
    alg_sha = sha;
    bit_offset = off;
    @(negedge clk);
    start = 1'b0;
    ncap = 0;
    done_seen = 1'b0;
    stall_err = 0;
  endtask

  task automatic put_beat(input logic [7:0] d, input bit last, input bit empty, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    in_empty = empty;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_empty = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_msg(input int gap);
    if (msg_len == 0) put_beat(8'h00, 1'b1, 1'b1, gap);
    for (int i = 0; i < msg_len; i++)
      put_beat(msg[i], (i == msg_len - 1), 1'b0, gap);
  endtask

  task automatic finish_and_compare(input string req);
    int t;
    t = 0;
    while (!done_seen && t < 3000) begin
      @(negedge clk);
      t++;
    end
    while (hash_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(req, "word count", 32'(ncap), 32'(exp_n));
    for (int w = 0; w < exp_n && w < ncap; w++) begin
      chk(req, $sformatf("word %0d", w), cap_word[w], exp_word[w]);
      chk("R8", $sformatf("chunk_end at %0d", w), 32'(cap_ce[w]), 32'((w % 16) == 15));
      chk("R8", $sformatf("done at %0d", w), 32'(cap_done[w]), 32'(w == exp_n - 1));
    end
    chk("R9", "activity while busy", 32'(stall_err), 32'd0);
  endtask

  task automatic run_msg(input string req, input bit sha, input logic [63:0] off, input int gap);
    build_expected(sha, off);
    pulse_start(sha, off);
    send_msg(gap);
    finish_and_compare(req);
  endtask

  // R1: idle after reset
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "in_ready", 32'(in_ready), 32'd0);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "chunk_end", 32'(chunk_end), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
  endtask

  // R3 R4 R5 R7: three bytes, MD5 ordering
  task automatic t_abc_md5();
    msg_len = 3; msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
    run_msg("R4", 1'b0, 64'd0, 0);
    chk("R3", "md5 word0", cap_word[0], 32'h80636261);
    chk("R7", "md5 len lo", cap_word[14], 32'h00000018);
  endtask

  // R3 R7: three bytes, SHA-1 ordering, idle gaps between beats
  task automatic t_abc_sha();
    msg_len = 3; msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
    run_msg("R3", 1'b1, 64'd0, 1);
    chk("R3", "sha word0", cap_word[0], 32'h61626380);
    chk("R7", "sha len lo", cap_word[15], 32'h00000018);
  endtask

  // R10: empty message
  task automatic t_empty();
    fill_msg(0, 0);
    run_msg("R10", 1'b1, 64'd0, 0);
    chk("R10", "marker only", cap_word[0], 32'h80000000);
  endtask

  // R5: marker in word 13, single chunk
  task automatic t_fit55();
    fill_msg(55, 3);
    run_msg("R5", 1'b0, 64'd0, 0);
  endtask

  // R6: marker words at index 14 and 15, and marker opening a new chunk
  task automatic t_spill();
    fill_msg(56, 9);
    run_msg("R6", 1'b1, 64'd0, 0);
    fill_msg(62, 17);
    run_msg("R6", 1'b0, 64'd0, 0);
    fill_msg(64, 21);
    run_msg("R4", 1'b1, 64'd0, 2);
  endtask

  // R7: keyed-state offset and a length with a nonzero upper half
  task automatic t_offset();
    fill_msg(5, 40);
    run_msg("R7", 1'b1, 64'd512, 0);
    chk("R7", "offset length", cap_word[15], 32'd552);
    fill_msg(7, 50);
    run_msg("R7", 1'b0, 64'h0000_0003_0000_0000, 0);
    chk("R7", "md5 len hi", cap_word[15], 32'h00000003);
  endtask

  // R8 R9: three chunks with pauses between them
  task automatic t_long();
    fill_msg(130, 77);
    run_msg("R8", 1'b0, 64'd0, 0);
  endtask

  // R2: restart in mid-message discards the partial one
  task automatic t_restart();
    fill_msg(6, 99);
    pulse_start(1'b1, 64'd1000);
    send_partial();
    msg_len = 3; msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
    run_msg("R2", 1'b0, 64'd0, 0);
  endtask

  task automatic send_partial();
    for (int i = 0; i < msg_len; i++) put_beat(msg[i], 1'b0, 1'b0, 0);
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_abc_md5();
    t_abc_sha();
    t_empty();
    t_fit55();
    t_spill();
    t_offset();
    t_long();
    t_restart();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule